// File: doc/BRIEF.md
# Linear CCD Readout Timing Generator

This block sequences a 128-element linear light sensor whose pixel clock must never stop. A divider derives a pixel-rate enable from the system clock, and that enable pulses without interruption in every state. A period counter measures the voxel period in pixel ticks. At the end of each period it issues a voxel strobe. The strobe closes the current integration window and opens a charge-transfer phase. A serial shift phase of exactly one pixel tick per element follows. The next integration starts at the strobe, so the readout of one frame runs while the following frame integrates.

Converter words arrive on a data input qualified by a valid strobe. The block numbers the first 128 words after each strobe with a 7-bit element index and marks index 0 as start of frame. It writes index, marker and 14-bit word as one entry into a first-word-fall-through FIFO that the consumer drains. A word that finds the FIFO full is lost and sets a sticky overflow flag. The strobe is also an output, so a scan waveform sequencer can step in lock with the sensor.

The sequencer is a four-state machine:
- FILL: the first integration after reset, with nothing to read out.
- XFER: the transfer, lasting XFER_CYC pixel ticks. The strobe is high during its first tick.
- SHIFT: NPIX pixel ticks.
- IDLE: readout is done and integration continues.

Its transitions are:
- FILL→XFER and IDLE→XFER at a period end.
- XFER→SHIFT after the last transfer tick.
- SHIFT→IDLE after the last element.
- SHIFT→XFER when the last element coincides with a period end, which happens at the minimum period.

Top module: `ccd_readout_timer`

## Requirements
- R1: `pix_ce` is high for one clock out of every PIX_DIV clocks (default 4). It keeps this rhythm without interruption from reset release onward, whatever the sequencer state.
- R2: `voxel_strobe` rises only directly after a `pix_ce` clock. It stays high for exactly one pixel period (PIX_DIV clocks) and once per voxel period. The first strobe after reset comes after the minimum period.
- R3: The voxel period, counted in `pix_ce` ticks between strobe rises, equals `cfg_period`. The value is sampled at each strobe. Values below MIN_PER = NPIX + XFER_CYC (default 130) are raised to MIN_PER.
- R4: `xfer_en` is high for XFER_CYC pixel periods (default 2), starting with the strobe. `shift_en` follows immediately for exactly NPIX pixel periods (128), and the two are never high together.
- R5: Each accepted word is written with index 0, 1, 2 … in arrival order since the last strobe, and its data is unchanged. `rd_sof` is 1 for index 0 and 0 for every other index.
- R6: At most NPIX words per frame are accepted. Words beyond the 128th, and words arriving before the first strobe after reset, are discarded with no FIFO entry and no overflow.
- R7: A word that finds the FIFO full is dropped and sets `overflow`. The flag holds until `ovf_clr` is pulsed, and a set in the same cycle wins. The index still advances past a dropped word, so later entries carry their true element position.
- R8: The FIFO returns entries in write order. Its head is visible on `rd_*` whenever `fifo_empty` is 0, and `fifo_rd` pops it. A `fifo_rd` while empty has no effect.
- R9: During and right after reset, `voxel_strobe`, `xfer_en`, `shift_en` and `overflow` are 0 and `fifo_empty` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_period | input | 16 | Voxel period in pixel ticks (clamped to MIN_PER) |
| adc_valid | input | 1 | Converter word valid |
| adc_data | input | 14 | Converter word |
| ovf_clr | input | 1 | Clears the sticky overflow flag |
| fifo_rd | input | 1 | Pops the FIFO head |
| pix_ce | output | 1 | Pixel clock enable, free running |
| voxel_strobe | output | 1 | End of integration / start of transfer, one pixel period wide |
| xfer_en | output | 1 | Parallel transfer phase |
| shift_en | output | 1 | Serial shift phase |
| fifo_empty | output | 1 | FIFO holds no entry |
| fifo_full | output | 1 | FIFO holds FIFO_DEPTH entries |
| rd_data | output | 14 | Head entry: converter word |
| rd_index | output | 7 | Head entry: element index |
| rd_sof | output | 1 | Head entry: start-of-frame marker |
| overflow | output | 1 | Sticky FIFO overflow flag |

## Verification
The checker watches the local timing relations on every cycle:
- no gap of PIX_DIV or more clocks between pixel enables;
- a strobe that rises only after an enable and holds until the next one;
- a shift phase that follows a transfer phase and spans exactly NPIX ticks;
- an overflow flag that rises only with a full FIFO and stays set without a clear.

Only the directed scenarios can show the end-to-end behaviour: the clamped and long periods measured between strobes, the exact index, marker and data of every entry, the discarding of surplus and early words, the true indices after a drop, and the harmless pops on an empty FIFO.

// File: rtl/ccdt_pkg.sv
package ccdt_pkg;
    typedef enum logic [1:0] {
        S_FILL  = 2'd0,
        S_XFER  = 2'd1,
        S_SHIFT = 2'd2,
        S_IDLE  = 2'd3
    } seq_state_t;
endpackage

// File: rtl/ccdt_pixdiv.sv
module ccdt_pixdiv #(
    parameter int PIX_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic pix_ce
);
    localparam int DW = (PIX_DIV > 1) ? $clog2(PIX_DIV) : 1;
    localparam logic [DW-1:0] LAST = DW'(PIX_DIV - 1);

    logic [DW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (cnt == LAST)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    assign pix_ce = (cnt == LAST);
endmodule

// File: rtl/ccdt_seq.sv
module ccdt_seq
    import ccdt_pkg::*;
#(
    parameter int NPIX     = 128,
    parameter int XFER_CYC = 2,
    parameter int PER_W    = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pix_ce,
    input  logic [PER_W-1:0] cfg_period,
    output logic             voxel_strobe,
    output logic             xfer_en,
    output logic             shift_en,
    output logic             frame_go
);
    localparam int MIN_PER = NPIX + XFER_CYC;
    localparam int SW      = $clog2(MIN_PER);
    localparam logic [PER_W-1:0] MIN_P = PER_W'(MIN_PER);

    seq_state_t       state, nxt;
    logic [SW-1:0]    step, step_n;
    logic [PER_W-1:0] pcnt, per_q, per_cfg;
    logic             period_end;

    assign per_cfg    = (cfg_period < MIN_P) ? MIN_P : cfg_period;
    assign period_end = (pcnt == per_q - 1'b1);
    assign frame_go   = pix_ce && period_end;

    // period counter: runs through integration and readout alike
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pcnt  <= '0;
            per_q <= MIN_P;
        end else if (pix_ce) begin
            if (period_end) begin
                pcnt  <= '0;
                per_q <= per_cfg;
            end else begin
                pcnt <= pcnt + 1'b1;
            end
        end
    end

    // next-state logic
    always_comb begin
        nxt    = state;
        step_n = step;
        if (period_end) begin
            nxt    = S_XFER;
            step_n = '0;
        end else begin
            unique case (state)
                S_FILL, S_IDLE: begin
                    nxt = state;
                end
                S_XFER: begin
                    if (step == SW'(XFER_CYC - 1)) begin
                        nxt    = S_SHIFT;
                        step_n = '0;
                    end else begin
                        step_n = step + 1'b1;
                    end
                end
                S_SHIFT: begin
                    if (step == SW'(NPIX - 1)) begin
                        nxt    = S_IDLE;
                        step_n = '0;
                    end else begin
                        step_n = step + 1'b1;
                    end
                end
                default: nxt = S_FILL;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_FILL;
            step  <= '0;
        end else if (pix_ce) begin
            state <= nxt;
            step  <= step_n;
        end
    end

    // outputs
    always_comb begin
        voxel_strobe = 1'b0;
        xfer_en      = 1'b0;
        shift_en     = 1'b0;
        unique case (state)
            S_FILL, S_IDLE: ;
            S_XFER: begin
                xfer_en      = 1'b1;
                voxel_strobe = (step == '0);
            end
            S_SHIFT: shift_en = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/ccdt_tagger.sv
module ccdt_tagger #(
    parameter int NPIX  = 128,
    parameter int ADC_W = 14,
    parameter int IW    = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_go,
    input  logic              adc_valid,
    input  logic [ADC_W-1:0]  adc_data,
    input  logic              fifo_full,
    input  logic              ovf_clr,
    output logic              wr_en,
    output logic [ADC_W+IW:0] wr_entry,
    output logic              overflow
);
    logic [IW:0] idx;
    logic        in_win;
    logic        take;

    assign in_win   = (idx < (IW+1)'(NPIX));
    assign take     = adc_valid && in_win;
    assign wr_en    = take && !fifo_full;
    assign wr_entry = {(idx == '0), idx[IW-1:0], adc_data};

    // a word in the frame_go cycle still belongs to the closing frame
    always_ff @(posedge clk) begin
        if (!rst_n)
            idx <= (IW+1)'(NPIX);
        else if (frame_go)
            idx <= '0;
        else if (take)
            idx <= idx + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            overflow <= 1'b0;
        else if (take && fifo_full)
            overflow <= 1'b1;
        else if (ovf_clr)
            overflow <= 1'b0;
    end
endmodule

// File: rtl/ccdt_fifo.sv
module ccdt_fifo #(
    parameter int W     = 22,
    parameter int DEPTH = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [W-1:0] din,
    input  logic         rd,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [AW:0]   cnt;
    logic          do_wr, do_rd;

    assign empty = (cnt == '0);
    assign full  = (cnt == (AW+1)'(DEPTH));
    assign do_wr = wr && !full;
    assign do_rd = rd && !empty;
    assign dout  = mem[rp];

    always_ff @(posedge clk) begin
        if (do_wr)
            mem[wp] <= din;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_wr)
                wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
            if (do_rd)
                rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
            if (do_wr && !do_rd)
                cnt <= cnt + 1'b1;
            else if (do_rd && !do_wr)
                cnt <= cnt - 1'b1;
        end
    end
endmodule

// File: rtl/ccd_readout_timer.sv
module ccd_readout_timer #(
    parameter int NPIX       = 128,
    parameter int XFER_CYC   = 2,
    parameter int PIX_DIV    = 4,
    parameter int ADC_W      = 14,
    parameter int PER_W      = 16,
    parameter int FIFO_DEPTH = 16,
    parameter int IW         = $clog2(NPIX)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PER_W-1:0] cfg_period,
    input  logic             adc_valid,
    input  logic [ADC_W-1:0] adc_data,
    input  logic             ovf_clr,
    input  logic             fifo_rd,
    output logic             pix_ce,
    output logic             voxel_strobe,
    output logic             xfer_en,
    output logic             shift_en,
    output logic             fifo_empty,
    output logic             fifo_full,
    output logic [ADC_W-1:0] rd_data,
    output logic [IW-1:0]    rd_index,
    output logic             rd_sof,
    output logic             overflow
);
    localparam int EW = ADC_W + IW + 1;

    logic          frame_go;
    logic          fifo_wr;
    logic [EW-1:0] wr_entry, head;

    ccdt_pixdiv #(.PIX_DIV(PIX_DIV)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .pix_ce (pix_ce)
    );

    ccdt_seq #(.NPIX(NPIX), .XFER_CYC(XFER_CYC), .PER_W(PER_W)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .pix_ce       (pix_ce),
        .cfg_period   (cfg_period),
        .voxel_strobe (voxel_strobe),
        .xfer_en      (xfer_en),
        .shift_en     (shift_en),
        .frame_go     (frame_go)
    );

    ccdt_tagger #(.NPIX(NPIX), .ADC_W(ADC_W), .IW(IW)) u_tag (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_go  (frame_go),
        .adc_valid (adc_valid),
        .adc_data  (adc_data),
        .fifo_full (fifo_full),
        .ovf_clr   (ovf_clr),
        .wr_en     (fifo_wr),
        .wr_entry  (wr_entry),
        .overflow  (overflow)
    );

    ccdt_fifo #(.W(EW), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (fifo_wr),
        .din   (wr_entry),
        .rd    (fifo_rd),
        .dout  (head),
        .empty (fifo_empty),
        .full  (fifo_full)
    );

    assign rd_sof   = head[EW-1];
    assign rd_index = head[EW-2:ADC_W];
    assign rd_data  = head[ADC_W-1:0];
endmodule

// File: rtl/ccdt_checker.sv
module ccdt_checker #(
    parameter int PIX_DIV = 4,
    parameter int NPIX    = 128
) (
    input logic clk,
    input logic rst_n,
    input logic pix_ce,
    input logic voxel_strobe,
    input logic xfer_en,
    input logic shift_en,
    input logic overflow,
    input logic ovf_clr,
    input logic fifo_full,
    input logic fifo_empty
);
    logic [15:0] gap;
    logic [15:0] scnt;

    always_ff @(posedge clk) begin
        if (!rst_n)
            gap <= '0;
        else if (pix_ce)
            gap <= '0;
        else
            gap <= gap + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || !shift_en)
            scnt <= '0;
        else if (pix_ce)
            scnt <= scnt + 1'b1;
    end

    assert_pix_gap_R1: assert property (@(posedge clk) disable iff (!rst_n)
        gap < 16'(PIX_DIV));

    assert_strobe_after_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(voxel_strobe) |-> $past(pix_ce));

    assert_strobe_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (voxel_strobe && !pix_ce) |=> voxel_strobe);

    assert_shift_after_xfer_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(shift_en) |-> $past(xfer_en));

    assert_shift_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(shift_en) |-> (scnt == 16'(NPIX)));

    assert_ovf_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow && !ovf_clr) |=> overflow);

    assert_ovf_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overflow) |-> $past(fifo_full));

    assert_fifo_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(fifo_empty && fifo_full));
endmodule

bind ccd_readout_timer ccdt_checker #(.PIX_DIV(PIX_DIV), .NPIX(NPIX)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .pix_ce       (pix_ce),
    .voxel_strobe (voxel_strobe),
    .xfer_en      (xfer_en),
    .shift_en     (shift_en),
    .overflow     (overflow),
    .ovf_clr      (ovf_clr),
    .fifo_full    (fifo_full),
    .fifo_empty   (fifo_empty)
);

// File: tb/sim_ccd_readout_timer.sv
`timescale 1ns/1ps
module sim_ccd_readout_timer;
    localparam int NPIX = 128;
    localparam int XFER = 2;
    localparam int PDIV = 4;
    localparam int MINP = NPIX + XFER;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cfg_period = 16'd0;
    logic        adc_valid = 1'b0;
    logic [13:0] adc_data = 14'd0;
    logic        ovf_clr = 1'b0;
    logic        fifo_rd = 1'b0;
    logic        pix_ce, voxel_strobe, xfer_en, shift_en;
    logic        fifo_empty, fifo_full, rd_sof, overflow;
    logic [13:0] rd_data;
    logic [6:0]  rd_index;

    int n_tests = 0;
    int n_fail  = 0;

    // stimulus controls
    logic        conv_on = 1'b0;
    logic        man_valid = 1'b0;
    logic [13:0] man_data = 14'd0;
    logic [13:0] salt = 14'd0;
    int          conv_k = 0;
    logic        rd_on = 1'b0;
    logic        rd_force = 1'b0;

    // captured entries
    int          n_got = 0;
    int          g_idx [512];
    logic        g_sof [512];
    logic [13:0] g_dat [512];

    always #2.5 clk = ~clk;

    ccd_readout_timer u0 (
        .clk(clk), .rst_n(rst_n), .cfg_period(cfg_period),
        .adc_valid(adc_valid), .adc_data(adc_data), .ovf_clr(ovf_clr),
        .fifo_rd(fifo_rd), .pix_ce(pix_ce), .voxel_strobe(voxel_strobe),
        .xfer_en(xfer_en), .shift_en(shift_en), .fifo_empty(fifo_empty),
        .fifo_full(fifo_full), .rd_data(rd_data), .rd_index(rd_index),
        .rd_sof(rd_sof), .overflow(overflow)
    );

    function automatic logic [13:0] pat(int i, logic [13:0] s);
        return 14'((i * 97 + 13) & 16383) ^ s;
    endfunction

    // converter model: one word per shift tick, plus manual words
    initial begin
        logic prev_s;
        prev_s = 1'b0;
        forever begin
            @(negedge clk);
            if (voxel_strobe && !prev_s) conv_k = 0;
            prev_s = voxel_strobe;
            if (man_valid) begin
                adc_valid <= 1'b1;
                adc_data  <= man_data;
            end else if (conv_on && shift_en && pix_ce) begin
                adc_valid <= 1'b1;
                adc_data  <= pat(conv_k, salt);
                conv_k = conv_k + 1;
            end else begin
                adc_valid <= 1'b0;
            end
        end
    end

    // consumer model
    initial begin
        forever begin
            @(negedge clk);
            if (rd_on && !fifo_empty) begin
                if (n_got < 512) begin
                    g_idx[n_got] = int'(rd_index);
                    g_sof[n_got] = rd_sof;
                    g_dat[n_got] = rd_data;
                end
                n_got = n_got + 1;
                fifo_rd <= 1'b1;
            end else begin
                fifo_rd <= rd_force;
            end
        end
    end

    task automatic check(input logic ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_rise();
        while (voxel_strobe) @(negedge clk);
        while (!voxel_strobe) @(negedge clk);
    endtask

    task automatic measure(output int ticks, output int sw, output int xt, output int st);
        logic prev, cur;
        ticks = 0; sw = 0; xt = 0; st = 0;
        prev = 1'b1;
        forever begin
            if (pix_ce) ticks++;
            if (pix_ce && xfer_en) xt++;
            if (pix_ce && shift_en) st++;
            if (voxel_strobe) sw++;
            @(negedge clk);
            cur = voxel_strobe;
            if (cur && !prev) break;
            prev = cur;
        end
    endtask

    task automatic t_reset();
        repeat (4) @(negedge clk);
        check(!voxel_strobe && !xfer_en && !shift_en && !overflow && fifo_empty,
              "R9 reset state", int'({voxel_strobe, xfer_en, shift_en, overflow, fifo_empty}), 1);
        rst_n = 1'b1;
        @(negedge clk);
        check(!voxel_strobe && !xfer_en && !shift_en && !overflow && fifo_empty,
              "R9 after release", int'({voxel_strobe, xfer_en, shift_en, overflow, fifo_empty}), 1);
        // words before the first strobe are discarded (R6)
        rd_on = 1'b0;
        man_data = 14'h0abc;
        man_valid = 1'b1;
        repeat (6) @(negedge clk);
        man_valid = 1'b0;
        repeat (3) @(negedge clk);
        check(fifo_empty, "R6 early words dropped", int'(fifo_empty), 1);
        check(!overflow, "R6 early words no overflow", int'(overflow), 0);
    endtask

    task automatic t_pixclk();
        int cnt, gap, maxgap;
        cnt = 0; gap = 0; maxgap = 0;
        for (int i = 0; i < 800; i++) begin
            @(negedge clk);
            if (pix_ce) begin cnt++; gap = 0; end
            else begin gap++; if (gap > maxgap) maxgap = gap; end
        end
        check(cnt == 800 / PDIV, "R1 pix_ce count", cnt, 800 / PDIV);
        check(maxgap == PDIV - 1, "R1 pix_ce gap", maxgap, PDIV - 1);
    endtask

    task automatic t_min_period();
        int ticks, sw, xt, st;
        cfg_period = 16'd10;
        wait_rise();
        wait_rise();
        measure(ticks, sw, xt, st);
        check(ticks == MINP, "R3 clamp to minimum", ticks, MINP);
        check(sw == PDIV, "R2 strobe width", sw, PDIV);
        check(xt == XFER, "R4 transfer ticks", xt, XFER);
        check(st == NPIX, "R4 shift ticks", st, NPIX);
    endtask

    task automatic t_long_period();
        int ticks, sw, xt, st;
        cfg_period = 16'd300;
        wait_rise();
        wait_rise();
        measure(ticks, sw, xt, st);
        check(ticks == 300, "R3 programmed period", ticks, 300);
        check(st == NPIX, "R4 shift ticks long period", st, NPIX);
        check(sw == PDIV, "R2 strobe width long period", sw, PDIV);
    endtask

    task automatic t_frame_data();
        int bad;
        cfg_period = 16'd200;
        salt = 14'h0155;
        rd_on = 1'b1;
        conv_on = 1'b0;
        wait_rise();
        n_got = 0;
        conv_on = 1'b1;
        wait_rise();
        conv_on = 1'b0;
        repeat (30) @(negedge clk);
        check(n_got == NPIX, "R5 entries per frame", n_got, NPIX);
        bad = 0;
        for (int i = 0; i < NPIX && i < n_got; i++) begin
            if (g_idx[i] != i || g_sof[i] != (i == 0) || g_dat[i] != pat(i, salt)) begin
                if (bad == 0)
                    $display("FAIL R5 entry %0d: idx %0d sof %0d data %0h expected idx %0d sof %0d data %0h",
                             i, g_idx[i], g_sof[i], g_dat[i], i, (i == 0), pat(i, salt));
                bad++;
            end
        end
        n_tests++;
        if (bad != 0) n_fail++;
    endtask

    task automatic t_extra_words();
        cfg_period = 16'd300;
        salt = 14'h02aa;
        rd_on = 1'b1;
        wait_rise();
        n_got = 0;
        conv_on = 1'b1;
        while (!shift_en) @(negedge clk);
        while (shift_en) @(negedge clk);
        conv_on = 1'b0;
        repeat (3) @(negedge clk);
        man_data = 14'h1111;
        man_valid = 1'b1;
        repeat (6) @(negedge clk);
        man_valid = 1'b0;
        wait_rise();
        repeat (30) @(negedge clk);
        check(n_got == NPIX, "R6 surplus words dropped", n_got, NPIX);
        check(!overflow, "R6 surplus no overflow", int'(overflow), 0);
    endtask

    task automatic t_overflow();
        int bad;
        cfg_period = 16'd200;
        salt = 14'h0033;
        rd_on = 1'b0;
        conv_on = 1'b0;
        wait_rise();
        n_got = 0;
        conv_on = 1'b1;
        while (conv_k < 60) @(negedge clk);
        check(overflow, "R7 overflow set", int'(overflow), 1);
        rd_on = 1'b1;
        wait_rise();
        conv_on = 1'b0;
        repeat (40) @(negedge clk);
        check(n_got > 17 && g_idx[15] == 15 && g_idx[16] >= 60,
              "R7 index advances past drops", (n_got > 16) ? g_idx[16] : -1, 60);
        check(n_got > 0 && g_idx[n_got - 1] == NPIX - 1, "R7 last index",
              (n_got > 0) ? g_idx[n_got - 1] : -1, NPIX - 1);
        bad = 0;
        for (int i = 0; i < n_got && i < 512; i++)
            if (g_dat[i] != pat(g_idx[i], salt) || g_sof[i] != (g_idx[i] == 0)) bad++;
        check(bad == 0, "R7 kept entries consistent", bad, 0);
        check(overflow, "R7 overflow sticky", int'(overflow), 1);
        ovf_clr = 1'b1;
        @(negedge clk);
        ovf_clr = 1'b0;
        @(negedge clk);
        check(!overflow, "R7 overflow cleared", int'(overflow), 0);
    endtask

    task automatic t_empty_pop();
        int bad;
        rd_on = 1'b0;
        rd_force = 1'b1;
        repeat (8) @(negedge clk);
        rd_force = 1'b0;
        check(fifo_empty, "R8 empty pop harmless", int'(fifo_empty), 1);
        salt = 14'h0f0f;
        rd_on = 1'b1;
        wait_rise();
        n_got = 0;
        conv_on = 1'b1;
        wait_rise();
        conv_on = 1'b0;
        repeat (30) @(negedge clk);
        bad = 0;
        for (int i = 0; i < n_got && i < 512; i++)
            if (g_idx[i] != i || g_dat[i] != pat(i, salt)) bad++;
        check(n_got == NPIX && bad == 0, "R8 order after empty pops", n_got - bad, NPIX);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_pixclk();
        t_min_period();
        t_long_period();
        t_frame_data();
        t_extra_words();
        t_overflow();
        t_empty_pop();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule